// File: doc/BRIEF.md
# Multiplexed External Memory Bus Controller

This block connects a CPU data-space request port to an external parallel SRAM bus. On that bus one 8-bit lane carries first the low address byte and then the data byte. The high address bits have their own output group. Each request is classified by address. Requests at or below the internal SRAM top boundary are served by internal memory. Requests above it go to the external bus when the interface is enabled.

An access runs through an address phase with the latch-enable strobe high, then a turnaround phase, then a strobe phase whose length is set by a wait-state code, then a hold phase. The CPU side sees a one-cycle ready pulse, and for reads the returned byte. While enabled, the controller takes ownership of the control pins, the shared lane and a configurable number of high address pins, overriding the normal port settings. While disabled, every pin follows the port, and the upper address range reaches no memory at all.

Top module: `xbus_ctrl`

## Requirements
- R1: An address greater than INT_TOP (default 0x10FF) with the interface enabled is external and is the only kind of access that drives the read strobe (`pad_ctl_o[1]`) or the write strobe (`pad_ctl_o[2]`) low. An address at or below INT_TOP is internal; INT_TOP itself is internal and INT_TOP+1 is external.
- R2: The first cycle after an accepted request is the address phase. In it the latch enable (`pad_ctl_o[0]`) is high and the lane drives the low address byte with all lane output enables high. In the second cycle the latch enable is low.
- R3: Wait code 0, 1, 2 and 3 gives 1, 2, 3 and 3 strobe-low cycles on an external access. Ready comes 4, 5, 6 and 7 cycles after the request cycle; code 3 adds one trailing hold cycle.
- R4: On an external read, the lane output enables are low from the second cycle and for every cycle that the read strobe is low. The returned byte is the lane value sampled at the clock edge that ends the last read-strobe-low cycle.
- R5: On an external write, the lane carries the write data from the second cycle onward, with the write strobe low for the strobe cycles. The lane still carries the data, enabled, in the cycle after the write strobe rises.
- R6: An internal access asserts `int_cs` for exactly one cycle (with `int_we` equal to the write flag) and never drives either strobe low. When enabled it still shows the latch enable and the lane address. It ignores the wait code, gives ready 4 cycles after the request, and a read returns `int_rdata` as sampled during the `int_cs` cycle.
- R7: While enabled, all three control pins have output enable 1 and carry the controller's values, and the lane output enables follow the controller.
- R8: The high-address width `cfg_hi_w` sets how many of the high pins, counted from bit 0, the controller owns; values above 8 count as 8. Owned pins drive the latched address bits 15:8 with output enable 1, and the other pins follow the port.
- R9: While disabled, every pad output and output enable equals the matching port input. An access above INT_TOP then asserts no `int_cs`, returns 0 and gives ready 4 cycles after the request.
- R10: With `cfg_compat` set, bit 1 of the wait code is ignored (only codes 0 and 1 take effect) and the high-address width is fixed at 8.
- R11: `cpu_ready` is a single-cycle pulse. A request raised while an access is in progress is ignored and starts no second access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_en | input | 1 | Interface enable |
| cfg_compat | input | 1 | Restricted compatibility mode |
| cfg_wait | input | 2 | Wait-state code |
| cfg_hi_w | input | HI_CW (4) | Number of high address pins owned |
| cpu_req | input | 1 | Request pulse, taken when idle |
| cpu_we | input | 1 | Write when 1, read when 0 |
| cpu_addr | input | 16 | Data-space address |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data, valid with ready |
| cpu_ready | output | 1 | Access completion pulse |
| int_cs | output | 1 | Internal memory select |
| int_we | output | 1 | Internal memory write |
| int_rdata | input | 8 | Internal memory read data |
| prt_ad_o | input | 8 | Port value for lane pins |
| prt_ad_oe | input | 8 | Port direction for lane pins |
| prt_hi_o | input | 8 | Port value for high address pins |
| prt_hi_oe | input | 8 | Port direction for high address pins |
| prt_ctl_o | input | 3 | Port value for control pins (0 latch, 1 read, 2 write) |
| prt_ctl_oe | input | 3 | Port direction for control pins |
| pad_ad_i | input | 8 | Lane pin input |
| pad_ad_o | output | 8 | Lane pin output |
| pad_ad_oe | output | 8 | Lane pin output enable |
| pad_hi_o | output | 8 | High address pin output |
| pad_hi_oe | output | 8 | High address pin output enable |
| pad_ctl_o | output | 3 | Control pins: 0 latch enable, 1 read strobe (low active), 2 write strobe (low active) |
| pad_ctl_oe | output | 3 | Control pin output enables |

## Verification
The hardest behaviour to reach from the ports is the sampling instant of a read: a controller that sampled one cycle early would still return a believable byte. The bench models the external latch and memory. The latch captures the lane while the latch enable is high. The memory answers with a value that mixes the latched address, the high pins and a count of the read-strobe-low cycles seen so far. Only a sample taken at the edge that ends the last strobe cycle returns the expected byte. A further request raised in the middle of an access checks that a busy controller ignores new requests.

// File: rtl/xbus_pkg.sv
package xbus_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADR,
    ST_TURN,
    ST_STRB,
    ST_HOLD,
    ST_XTRA
  } xb_state_e;

  localparam int CTL_ALE = 0;
  localparam int CTL_RD  = 1;
  localparam int CTL_WR  = 2;
  localparam int CTL_N   = 3;
endpackage

// File: rtl/xbus_decode.sv
module xbus_decode #(
  parameter int AW = 16,
  parameter int HW = 8,
  parameter int HCW = 4,
  parameter logic [AW-1:0] INT_TOP = 16'h10FF
) (
  input  logic [AW-1:0]  addr,
  input  logic           cfg_en,
  input  logic           cfg_compat,
  input  logic [1:0]     cfg_wait,
  input  logic [HCW-1:0] cfg_hi_w,
  output logic           is_ext,
  output logic           is_int,
  output logic [1:0]     wait_n,
  output logic           extra,
  output logic [HW-1:0]  hi_mask
);
  localparam logic [HCW-1:0] HW_C = HCW'(HW);

  logic [1:0]     code;
  logic [HCW-1:0] width;

  always_comb begin
    is_int = (addr <= INT_TOP);
    is_ext = cfg_en && (addr > INT_TOP);
    code   = cfg_compat ? {1'b0, cfg_wait[0]} : cfg_wait;
    wait_n = (code == 2'd3) ? 2'd2 : code;
    extra  = (code == 2'd3);
    if (cfg_compat || (cfg_hi_w > HW_C)) width = HW_C;
    else                                 width = cfg_hi_w;
  end

  for (genvar i = 0; i < HW; i++) begin : g_mask
    localparam logic [HCW-1:0] IDX = HCW'(i);
    assign hi_mask[i] = (IDX < width);
  end
endmodule

// File: rtl/xbus_seq.sv
module xbus_seq
  import xbus_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter logic [AW-1:0] INT_TOP = 16'h10FF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic          is_ext,
  input  logic          is_int,
  input  logic [1:0]    wait_n,
  input  logic          extra,
  input  logic [DW-1:0] ad_i,
  input  logic [DW-1:0] int_rdata,
  output logic          ale,
  output logic          rd_n,
  output logic          wr_n,
  output logic [DW-1:0] lane_o,
  output logic          lane_oe,
  output logic [AW-1:0] addr_q,
  output logic          int_cs,
  output logic          int_we,
  output logic [DW-1:0] rdata,
  output logic          ready
);
  xb_state_e     state_q, state_d;
  logic [1:0]    cnt_q, cnt_d;
  logic [1:0]    wait_q;
  logic          xtra_q, ext_q, int_q, we_q;
  logic [DW-1:0] wdata_q, rdata_q;
  logic          cap, last_strb, rd_cap;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    cap     = 1'b0;
    case (state_q)
      ST_IDLE: if (req) begin
        state_d = ST_ADR;
        cap     = 1'b1;
      end
      ST_ADR:  state_d = ST_TURN;
      ST_TURN: begin
        state_d = ST_STRB;
        cnt_d   = wait_q;
      end
      ST_STRB: if (cnt_q == 2'd0) state_d = ST_HOLD;
               else               cnt_d   = cnt_q - 2'd1;
      ST_HOLD: state_d = xtra_q ? ST_XTRA : ST_IDLE;
      ST_XTRA: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  assign last_strb = (state_q == ST_STRB) && (cnt_q == 2'd0);
  assign rd_cap    = last_strb && !we_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      wait_q  <= '0;
      xtra_q  <= 1'b0;
      ext_q   <= 1'b0;
      int_q   <= 1'b0;
      we_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      if (cap) begin
        addr_q  <= addr;
        wdata_q <= wdata;
        we_q    <= we;
        ext_q   <= is_ext;
        int_q   <= is_int;
        wait_q  <= is_ext ? wait_n : 2'd0;
        xtra_q  <= is_ext && extra;
      end
      if (rd_cap) begin
        if (ext_q)      rdata_q <= ad_i;
        else if (int_q) rdata_q <= int_rdata;
        else            rdata_q <= '0;
      end
    end
  end

  always_comb begin
    ale     = (state_q == ST_ADR);
    lane_oe = ale || (we_q && (state_q != ST_IDLE));
    lane_o  = ale ? addr_q[DW-1:0] : wdata_q;
    rd_n    = !((state_q == ST_STRB) && ext_q && !we_q);
    wr_n    = !((state_q == ST_STRB) && ext_q && we_q);
    int_cs  = (state_q == ST_STRB) && int_q;
    int_we  = int_cs && we_q;
    rdata   = rdata_q;
    ready   = ((state_q == ST_HOLD) && !xtra_q) || (state_q == ST_XTRA);
  end

  AST_EXT_ONLY_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_n || !wr_n) |-> (addr_q > INT_TOP)); // R1
  AST_ALE_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    ale |-> (rd_n && wr_n)); // R2
  AST_RD_LANE_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> !lane_oe); // R4
  AST_WR_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_n) |-> lane_oe); // R5
  AST_INT_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    int_cs |-> (rd_n && wr_n)); // R6
  AST_READY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> !ready); // R11
endmodule

// File: rtl/xbus_pinmux.sv
module xbus_pinmux
  import xbus_pkg::*;
#(
  parameter int DW = 8,
  parameter int HW = 8
) (
  input  logic             en,
  input  logic [HW-1:0]    hi_mask,
  input  logic [HW-1:0]    hi_val,
  input  logic [DW-1:0]    lane_o,
  input  logic             lane_oe,
  input  logic [CTL_N-1:0] ctl_val,
  input  logic [DW-1:0]    prt_ad_o,
  input  logic [DW-1:0]    prt_ad_oe,
  input  logic [HW-1:0]    prt_hi_o,
  input  logic [HW-1:0]    prt_hi_oe,
  input  logic [CTL_N-1:0] prt_ctl_o,
  input  logic [CTL_N-1:0] prt_ctl_oe,
  output logic [DW-1:0]    pad_ad_o,
  output logic [DW-1:0]    pad_ad_oe,
  output logic [HW-1:0]    pad_hi_o,
  output logic [HW-1:0]    pad_hi_oe,
  output logic [CTL_N-1:0] pad_ctl_o,
  output logic [CTL_N-1:0] pad_ctl_oe
);
  always_comb begin
    pad_ad_o   = en ? lane_o : prt_ad_o;
    pad_ad_oe  = en ? {DW{lane_oe}} : prt_ad_oe;
    pad_ctl_o  = en ? ctl_val : prt_ctl_o;
    pad_ctl_oe = en ? {CTL_N{1'b1}} : prt_ctl_oe;
  end

  for (genvar i = 0; i < HW; i++) begin : g_hi
    logic own;
    assign own          = en && hi_mask[i];
    assign pad_hi_o[i]  = own ? hi_val[i] : prt_hi_o[i];
    assign pad_hi_oe[i] = own ? 1'b1 : prt_hi_oe[i];
  end
endmodule

// File: rtl/xbus_ctrl.sv
module xbus_ctrl
  import xbus_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter logic [AW-1:0] INT_TOP = 16'h10FF,
  localparam int HW = AW - DW,
  localparam int HI_CW = $clog2(HW + 2)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_en,
  input  logic             cfg_compat,
  input  logic [1:0]       cfg_wait,
  input  logic [HI_CW-1:0] cfg_hi_w,
  input  logic             cpu_req,
  input  logic             cpu_we,
  input  logic [AW-1:0]    cpu_addr,
  input  logic [DW-1:0]    cpu_wdata,
  output logic [DW-1:0]    cpu_rdata,
  output logic             cpu_ready,
  output logic             int_cs,
  output logic             int_we,
  input  logic [DW-1:0]    int_rdata,
  input  logic [DW-1:0]    prt_ad_o,
  input  logic [DW-1:0]    prt_ad_oe,
  input  logic [HW-1:0]    prt_hi_o,
  input  logic [HW-1:0]    prt_hi_oe,
  input  logic [CTL_N-1:0] prt_ctl_o,
  input  logic [CTL_N-1:0] prt_ctl_oe,
  input  logic [DW-1:0]    pad_ad_i,
  output logic [DW-1:0]    pad_ad_o,
  output logic [DW-1:0]    pad_ad_oe,
  output logic [HW-1:0]    pad_hi_o,
  output logic [HW-1:0]    pad_hi_oe,
  output logic [CTL_N-1:0] pad_ctl_o,
  output logic [CTL_N-1:0] pad_ctl_oe
);
  logic [1:0]    rst_pipe;
  logic          rst_sn;
  logic          is_ext, is_int, extra, ale, rd_n, wr_n, lane_oe;
  logic [1:0]    wait_n;
  logic [HW-1:0] hi_mask;
  logic [DW-1:0] lane_o;
  logic [AW-1:0] addr_q;
  logic [CTL_N-1:0] ctl_val;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sn = rst_pipe[1];

  xbus_decode #(.AW(AW), .HW(HW), .HCW(HI_CW), .INT_TOP(INT_TOP)) u_dec (
    .addr(cpu_addr), .cfg_en(cfg_en), .cfg_compat(cfg_compat),
    .cfg_wait(cfg_wait), .cfg_hi_w(cfg_hi_w), .is_ext(is_ext),
    .is_int(is_int), .wait_n(wait_n), .extra(extra), .hi_mask(hi_mask)
  );

  xbus_seq #(.AW(AW), .DW(DW), .INT_TOP(INT_TOP)) u_seq (
    .clk(clk), .rst_n(rst_sn), .req(cpu_req), .we(cpu_we),
    .addr(cpu_addr), .wdata(cpu_wdata), .is_ext(is_ext), .is_int(is_int),
    .wait_n(wait_n), .extra(extra), .ad_i(pad_ad_i),
    .int_rdata(int_rdata), .ale(ale), .rd_n(rd_n), .wr_n(wr_n),
    .lane_o(lane_o), .lane_oe(lane_oe), .addr_q(addr_q),
    .int_cs(int_cs), .int_we(int_we), .rdata(cpu_rdata),
    .ready(cpu_ready)
  );

  always_comb begin
    ctl_val          = '0;
    ctl_val[CTL_ALE] = ale;
    ctl_val[CTL_RD]  = rd_n;
    ctl_val[CTL_WR]  = wr_n;
  end

  xbus_pinmux #(.DW(DW), .HW(HW)) u_mux (
    .en(cfg_en), .hi_mask(hi_mask), .hi_val(addr_q[AW-1:DW]),
    .lane_o(lane_o), .lane_oe(lane_oe), .ctl_val(ctl_val),
    .prt_ad_o(prt_ad_o), .prt_ad_oe(prt_ad_oe), .prt_hi_o(prt_hi_o),
    .prt_hi_oe(prt_hi_oe), .prt_ctl_o(prt_ctl_o), .prt_ctl_oe(prt_ctl_oe),
    .pad_ad_o(pad_ad_o), .pad_ad_oe(pad_ad_oe), .pad_hi_o(pad_hi_o),
    .pad_hi_oe(pad_hi_oe), .pad_ctl_o(pad_ctl_o), .pad_ctl_oe(pad_ctl_oe)
  );

  AST_DIS_PASS: assert property (@(posedge clk) disable iff (!rst_sn)
    !cfg_en |-> (pad_ctl_oe == prt_ctl_oe && pad_hi_oe == prt_hi_oe)); // R9
  AST_EN_CTL_OWN: assert property (@(posedge clk) disable iff (!rst_sn)
    cfg_en |-> (pad_ctl_oe == {CTL_N{1'b1}})); // R7
endmodule

// File: tb/xbus_ctrl_bench.sv
module xbus_ctrl_bench;
  localparam int CLK_P = 10;
  localparam logic [15:0] TOP = 16'h10FF;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_en, cfg_compat, cpu_req, cpu_we;
  logic [1:0] cfg_wait;
  logic [3:0] cfg_hi_w;
  logic [15:0] cpu_addr;
  logic [7:0] cpu_wdata, cpu_rdata, int_rdata;
  logic cpu_ready, int_cs, int_we;
  logic [7:0] prt_ad_o, prt_ad_oe, prt_hi_o, prt_hi_oe;
  logic [2:0] prt_ctl_o, prt_ctl_oe, pad_ctl_o, pad_ctl_oe;
  logic [7:0] pad_ad_i, pad_ad_o, pad_ad_oe, pad_hi_o, pad_hi_oe;
  logic [7:0] lat;
  logic [3:0] rd_cnt;
  int n_chk = 0, n_err = 0;

  always #(CLK_P/2) clk = ~clk;

  xbus_ctrl u_xbus_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_compat(cfg_compat),
    .cfg_wait(cfg_wait), .cfg_hi_w(cfg_hi_w), .cpu_req(cpu_req),
    .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready), .int_cs(int_cs),
    .int_we(int_we), .int_rdata(int_rdata), .prt_ad_o(prt_ad_o),
    .prt_ad_oe(prt_ad_oe), .prt_hi_o(prt_hi_o), .prt_hi_oe(prt_hi_oe),
    .prt_ctl_o(prt_ctl_o), .prt_ctl_oe(prt_ctl_oe), .pad_ad_i(pad_ad_i),
    .pad_ad_o(pad_ad_o), .pad_ad_oe(pad_ad_oe), .pad_hi_o(pad_hi_o),
    .pad_hi_oe(pad_hi_oe), .pad_ctl_o(pad_ctl_o), .pad_ctl_oe(pad_ctl_oe)
  );

  // external latch and memory model
  always @(posedge clk) begin
    if (pad_ctl_o[0]) lat <= pad_ad_o;
    rd_cnt <= !pad_ctl_o[1] ? rd_cnt + 4'd1 : 4'd0;
  end
  assign pad_ad_i = lat ^ 8'h5A ^ pad_hi_o ^ {4'd0, rd_cnt};

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // lat_exp: ready cycle; n: wait count; kind: 0 none, 1 ext, 2 int
  task automatic run(input logic w, input logic [15:0] a, input logic [7:0] d,
                     input int lat_exp, input int n, input int kind,
                     input logic dbl);
    int rdy = 0, rdl = 0, wrl = 0, csn = 0;
    bit bad_rd = 0, bad_wr = 0, bad_hold = 0, bad_pass = 0, bad_int = 0;
    logic prev_wr = 1'b1;
    logic [7:0] rexp;
    int_rdata = a[7:0] ^ 8'hC3;
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = w; cpu_addr = a; cpu_wdata = d;
    for (int cyc = 1; cyc <= 12; cyc++) begin
      @(negedge clk);
      cpu_req = 1'b0;
      if (dbl && cyc == 2) begin cpu_req = 1'b1; cpu_addr = a ^ 16'h0F0F; end
      if (cfg_en && cyc == 1)
        check(pad_ctl_o[0] && pad_ad_o == a[7:0] && pad_ad_oe == 8'hFF,
              "R2 address phase", {pad_ctl_o[0], pad_ad_o, pad_ad_oe}, {1'b1, a[7:0], 8'hFF});
      if (cfg_en && cyc == 2) begin
        check(!pad_ctl_o[0], "R2 latch low in turn", pad_ctl_o[0], 0);
        if (!w) check(pad_ad_oe == 8'h00, "R4 lane released", pad_ad_oe, 0);
        else    check(pad_ad_o == d && pad_ad_oe == 8'hFF, "R5 data from turn", pad_ad_o, d);
      end
      if (cfg_en) check(pad_ctl_oe == 3'b111, "R7 control pins owned", pad_ctl_oe, 7);
      if (!cfg_en && (pad_ctl_o != prt_ctl_o || pad_ctl_oe != prt_ctl_oe ||
                      pad_ad_o != prt_ad_o || pad_ad_oe != prt_ad_oe ||
                      pad_hi_o != prt_hi_o || pad_hi_oe != prt_hi_oe)) bad_pass = 1;
      if (!pad_ctl_o[1] && cfg_en) begin rdl++; if (pad_ad_oe != 8'h00) bad_rd = 1; end
      if (!pad_ctl_o[2] && cfg_en) begin wrl++; if (pad_ad_o != d || pad_ad_oe != 8'hFF) bad_wr = 1; end
      if (cfg_en && pad_ctl_o[2] && !prev_wr && (pad_ad_o != d || pad_ad_oe != 8'hFF)) bad_hold = 1;
      prev_wr = cfg_en ? pad_ctl_o[2] : 1'b1;
      if (int_cs) begin csn++; if (int_we != w) bad_int = 1; end
      if (cpu_ready) begin rdy = cyc; break; end
    end
    rexp = (kind == 1) ? (a[7:0] ^ 8'h5A ^ a[15:8] ^ 8'(n)) :
           (kind == 2) ? (a[7:0] ^ 8'hC3) : 8'h00;
    check(rdy == lat_exp, (kind == 1) ? "R3 ready latency" : "R6/R9 ready latency", rdy, lat_exp);
    if (!w) check(cpu_rdata == rexp, (kind == 1) ? "R4 read sample" :
                  (kind == 2) ? "R6 internal read" : "R9 unmapped read", cpu_rdata, rexp);
    if (kind == 1) begin
      check((w ? wrl : rdl) == n + 1, "R3 strobe length", w ? wrl : rdl, n + 1);
      check((w ? rdl : wrl) == 0 && csn == 0, "R1 other strobe idle", rdl + wrl + csn, n + 1);
      if (!w) check(!bad_rd, "R4 lane free under read strobe", bad_rd, 0);
      else    check(!bad_wr && !bad_hold, "R5 write data held", {bad_wr, bad_hold}, 0);
    end else begin
      check(rdl == 0 && wrl == 0, "R1 R6 no strobes", rdl + wrl, 0);
      check(csn == ((kind == 2) ? 1 : 0) && !bad_int, "R6 R9 int select", csn, (kind == 2) ? 1 : 0);
    end
    if (!cfg_en) check(!bad_pass, "R9 pins follow port", bad_pass, 0);
    @(negedge clk);
    check(!cpu_ready, "R11 ready single pulse", cpu_ready, 0);
    if (dbl) begin
      bit seen = 0;
      for (int k = 0; k < 8; k++) begin
        @(negedge clk);
        if (cpu_ready || pad_ctl_o[0]) seen = 1;
      end
      check(!seen, "R11 busy request ignored", seen, 0);
    end
  endtask

  initial begin
    cfg_en = 1'b1; cfg_compat = 1'b0; cfg_wait = 2'd0; cfg_hi_w = 4'd8;
    cpu_req = 1'b0; cpu_we = 1'b0; cpu_addr = '0; cpu_wdata = '0;
    int_rdata = '0; prt_ad_o = 8'h96; prt_ad_oe = 8'h81; prt_hi_o = 8'h3C;
    prt_hi_oe = 8'h0F; prt_ctl_o = 3'b101; prt_ctl_oe = 3'b010;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(!cpu_ready && pad_ctl_o == 3'b110 && pad_ad_oe == 8'h00,
          "R7 reset state", {cpu_ready, pad_ctl_o, pad_ad_oe}, 8'h06);

    // sweep: compat x wait code x direction x region
    for (int cm = 0; cm < 2; cm++)
      for (int c = 0; c < 4; c++)
        for (int w = 0; w < 2; w++) begin
          int ce, nn, lt;
          logic [15:0] ea, ia;
          cfg_compat = cm[0]; cfg_wait = c[1:0];
          ce = cm ? (c & 1) : c;          // R10 effective code
          nn = (ce == 3) ? 2 : ce;
          lt = 4 + nn + ((ce == 3) ? 1 : 0);
          ea = 16'h8000 + 16'((cm * 8 + c * 2 + w) * 16'h0137);
          ia = 16'h0200 + 16'((cm * 8 + c * 2 + w) * 3);
          run(w[0], ea, 8'hA0 ^ 8'(c * 17 + w), lt, nn, 1, 1'b0);
          run(w[0], ia, 8'h3E ^ 8'(c), 4, 0, 2, 1'b0);
        end

    // boundary of internal region (R1)
    cfg_compat = 1'b0; cfg_wait = 2'd1;
    run(1'b0, TOP, 8'h00, 4, 0, 2, 1'b0);
    run(1'b0, TOP + 16'd1, 8'h00, 5, 1, 1, 1'b0);
    // request while busy (R11)
    run(1'b1, 16'hC4D2, 8'h77, 5, 1, 1, 1'b1);

    // high address width sweep (R8, R10)
    run(1'b0, 16'hB76A, 8'h00, 5, 1, 1, 1'b0);
    for (int hw = 0; hw < 10; hw++)
      for (int cm = 0; cm < 2; cm++) begin
        logic [7:0] m;
        cfg_hi_w = 4'(hw); cfg_compat = cm[0];
        m = (cm == 1 || hw >= 8) ? 8'hFF : 8'((1 << hw) - 1);
        @(negedge clk);
        check(pad_hi_oe == (m | (prt_hi_oe & ~m)) &&
              pad_hi_o == ((8'hB7 & m) | (prt_hi_o & ~m)),
              cm ? "R10 fixed high width" : "R8 high width", {pad_hi_oe, pad_hi_o},
              {(m | (prt_hi_oe & ~m)), ((8'hB7 & m) | (prt_hi_o & ~m))});
      end
    cfg_hi_w = 4'd8; cfg_compat = 1'b0;

    // disabled interface (R9)
    cfg_en = 1'b0; cfg_wait = 2'd2;
    run(1'b0, 16'h9123, 8'h00, 4, 0, 0, 1'b0);
    run(1'b1, 16'hE001, 8'h5C, 4, 0, 0, 1'b0);
    run(1'b0, 16'h0456, 8'h00, 4, 0, 2, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    #(CLK_P * 20000);
    n_chk++; n_err++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule